// File: doc/BRIEF.md
# Tagged Command Stream Expander

The expander sits between a source of 32-bit command words and the graphics core's input FIFO. The source can be a DMA fetcher or a raw host write window. The block reads the stream as a series of bursts. Each burst opens with one descriptor word, and a set of data words follows it. For every data word the block emits one pair: a 9-bit register tag and the 32-bit data word, 41 bits in all. The descriptor word itself never reaches the FIFO. It only tells the block which tag each following data word gets and how many data words belong to the burst.

The descriptor word has three fields:
- Bits 8:0 hold a register tag.
- Bits 15:14 hold the addressing mode.
- Bits 31:16 hold a count or a mask.

Bits 13:9 are not used. There are three modes:
- Hold sends count+1 words, all to one tag.
- Increment sends count+1 words, to ascending tags starting at the given one.
- Indexed treats tag bits 8:4 as a group. Each set bit of the mask picks one register of that group, and the block visits the picked registers from lowest to highest.

The fourth mode code is illegal. It carries no data and raises an error flag that stays set until reset.

The data path is combinational and adds no cycle. A data word is offered on the output in the same cycle it arrives, and it is taken from the source only when the FIFO accepts it. A descriptor is always taken at once.

Top module: `tag_stream_expander`

## Requirements
- R1: After reset the block waits for a descriptor. The input is ready, no pair is offered, and the error flag is low.
- R2: While the block waits for a descriptor, an offered word is taken in that cycle and produces no output pair.
- R3: A hold descriptor (mode field 0) with count n emits n+1 pairs. All of them carry the descriptor's tag, and each carries its data word unchanged.
- R4: A descriptor whose upper 16 bits are zero, in hold or increment mode, takes exactly one data word. The word after it is decoded as a new descriptor.
- R5: An increment descriptor (mode field 1) with count n emits n+1 pairs. The tags start at the given tag and rise by one per word, wrapping modulo 512.
- R6: An indexed descriptor (mode field 2) emits one pair per set bit k of the mask, with tag {bits 8:4 of the descriptor, k}. The pairs come in increasing k, and bits 3:0 of the descriptor are ignored. Example: mask 0x0032 in group 0x0F gives tags 0x0F1, 0x0F4, 0x0F5.
- R7: An indexed descriptor with an all-zero mask expects no data, and the next word is a descriptor.
- R8: A descriptor with mode field 3 expects no data, and the next word is a descriptor. It sets the error flag, which stays high until reset.
- R9: When a data word is offered while the FIFO is not ready, the input is not ready. The offered tag then holds until the pair is taken.
- R10: A pair is offered only when a data word is present at the input. With no input word, nothing is offered and the burst position does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A command word is present |
| in_word | input | 32 | Command word (descriptor or data) |
| in_ready | output | 1 | Command word is taken this cycle |
| out_valid | output | 1 | A tag/data pair is offered to the FIFO |
| out_tag | output | 9 | Register tag of the offered pair |
| out_data | output | 32 | Data of the offered pair |
| out_ready | input | 1 | FIFO can take a pair |
| err_mode | output | 1 | Sticky flag: an illegal mode was seen |

## Verification
Most faults in this block come from a wrong burst position: a counter that is off by one, a mask bit that is not cleared, or a phase flag that is wrong. Each of these shows at the ports within one word. Either a descriptor comes out as a pair with out_valid high, or a data word is swallowed silently, or the next pair carries the wrong tag. Every stream in the bench is therefore followed by a short known burst, so a wrong return to descriptor decoding shows up on the very next tag. Stalls are checked by holding the FIFO not ready on a data word and watching the tag and in_ready.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
  localparam int TSX_TAG_W  = 9;
  localparam int TSX_DATA_W = 32;
  localparam int TSX_FLD_W  = 16;
  localparam int TSX_OFS_W  = 4;
  localparam int TSX_MODE_LSB = 14;

  typedef enum logic [1:0] {
    MD_HOLD  = 2'd0,
    MD_INCR  = 2'd1,
    MD_INDEX = 2'd2,
    MD_RSVD  = 2'd3
  } tsx_mode_e;

  // index of lowest set bit of a group mask
  function automatic logic [TSX_OFS_W-1:0] low_index(input logic [TSX_FLD_W-1:0] m);
    logic [TSX_OFS_W-1:0] idx;
    idx = '0;
    for (int i = TSX_FLD_W - 1; i >= 0; i--) begin
      if (m[i]) idx = TSX_OFS_W'(i);
    end
    return idx;
  endfunction

  // mask with its lowest set bit cleared
  function automatic logic [TSX_FLD_W-1:0] drop_low(input logic [TSX_FLD_W-1:0] m);
    return m & (m - 1'b1);
  endfunction
endpackage

// File: rtl/tsx_desc_decode.sv
module tsx_desc_decode
  import tsx_pkg::*;
#(
  parameter int TAG_W    = TSX_TAG_W,
  parameter int DATA_W   = TSX_DATA_W,
  parameter int FLD_W    = TSX_FLD_W,
  parameter int MODE_LSB = TSX_MODE_LSB
) (
  input  logic [DATA_W-1:0] word,
  output tsx_mode_e         mode,
  output logic [TAG_W-1:0]  tag,
  output logic [FLD_W-1:0]  field,
  output logic              has_data,
  output logic              bad_mode
);
  localparam int FLD_LSB = DATA_W - FLD_W;

  always_comb begin
    mode  = tsx_mode_e'(word[MODE_LSB +: 2]);
    tag   = word[TAG_W-1:0];
    field = word[FLD_LSB +: FLD_W];
    unique case (mode)
      MD_HOLD, MD_INCR: begin has_data = 1'b1;          bad_mode = 1'b0; end
      MD_INDEX:         begin has_data = |field;        bad_mode = 1'b0; end
      default:          begin has_data = 1'b0;          bad_mode = 1'b1; end
    endcase
  end
endmodule

// File: rtl/tsx_sequencer.sv
module tsx_sequencer
  import tsx_pkg::*;
#(
  parameter int TAG_W = TSX_TAG_W,
  parameter int FLD_W = TSX_FLD_W,
  parameter int OFS_W = TSX_OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  tsx_mode_e        load_mode,
  input  logic [TAG_W-1:0] load_tag,
  input  logic [FLD_W-1:0] load_field,
  input  logic             step,
  output logic             busy,
  output tsx_mode_e        mode,
  output logic [TAG_W-1:0] cur_tag,
  output logic             last
);
  localparam int GRP_W = TAG_W - OFS_W;

  logic [TAG_W-1:0] tag_q;
  logic [FLD_W-1:0] fld_q;

  always_comb begin
    if (mode == MD_INDEX) begin
      cur_tag = {tag_q[TAG_W-1:OFS_W], low_index(fld_q)};
      last    = (drop_low(fld_q) == '0);
    end else begin
      cur_tag = tag_q;
      last    = (fld_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      mode  <= MD_HOLD;
      tag_q <= '0;
      fld_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      mode  <= load_mode;
      tag_q <= load_tag;
      fld_q <= load_field;
    end else if (step) begin
      if (last) busy <= 1'b0;
      unique case (mode)
        MD_INDEX: fld_q <= drop_low(fld_q);
        MD_INCR: begin
          tag_q <= tag_q + 1'b1;
          fld_q <= fld_q - 1'b1;
        end
        default:  fld_q <= fld_q - 1'b1;
      endcase
    end
  end

  logic [GRP_W-1:0] unused_grp;
  assign unused_grp = '0;
endmodule

// File: rtl/tsx_err_flag.sv
module tsx_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/tag_stream_expander.sv
module tag_stream_expander
  import tsx_pkg::*;
#(
  parameter int TAG_W    = TSX_TAG_W,
  parameter int DATA_W   = TSX_DATA_W,
  parameter int FLD_W    = TSX_FLD_W,
  parameter int OFS_W    = TSX_OFS_W,
  parameter int MODE_LSB = TSX_MODE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_word,
  output logic              in_ready,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              err_mode
);
  tsx_mode_e        dec_mode;
  logic [TAG_W-1:0] dec_tag;
  logic [FLD_W-1:0] dec_field;
  logic             dec_has_data;
  logic             dec_bad;

  logic             seq_busy;
  tsx_mode_e        seq_mode;
  logic [TAG_W-1:0] seq_tag;
  logic             seq_last;

  // named events for the checker
  logic hdr_phase;
  logic accept;
  logic desc_take;
  logic data_fire;

  assign hdr_phase = ~seq_busy;
  assign in_ready  = hdr_phase | out_ready;
  assign accept    = in_valid & in_ready;
  assign desc_take = accept & hdr_phase;
  assign data_fire = accept & ~hdr_phase;

  assign out_valid = in_valid & ~hdr_phase;
  assign out_tag   = seq_tag;
  assign out_data  = in_word;

  tsx_desc_decode #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .FLD_W(FLD_W), .MODE_LSB(MODE_LSB)
  ) i_dec (
    .word(in_word), .mode(dec_mode), .tag(dec_tag), .field(dec_field),
    .has_data(dec_has_data), .bad_mode(dec_bad)
  );

  tsx_sequencer #(
    .TAG_W(TAG_W), .FLD_W(FLD_W), .OFS_W(OFS_W)
  ) i_seq (
    .clk(clk), .rst_n(rst_n),
    .load(desc_take & dec_has_data), .load_mode(dec_mode),
    .load_tag(dec_tag), .load_field(dec_field),
    .step(data_fire),
    .busy(seq_busy), .mode(seq_mode), .cur_tag(seq_tag), .last(seq_last)
  );

  tsx_err_flag i_err (
    .clk(clk), .rst_n(rst_n), .set(desc_take & dec_bad), .flag(err_mode)
  );
endmodule

// File: rtl/tsx_checker.sv
module tsx_checker
  import tsx_pkg::*;
#(
  parameter int TAG_W = TSX_TAG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [TAG_W-1:0] out_tag,
  input logic             err_mode,
  input logic             hdr_phase,
  input logic             data_fire,
  input logic             seq_last,
  input tsx_mode_e        seq_mode
);
  assert_hdr_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_phase |-> (!out_valid && in_ready));

  assert_hold_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && seq_mode == MD_HOLD && !seq_last) |=> out_tag == $past(out_tag));

  assert_burst_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && seq_last) |=> hdr_phase);

  assert_incr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && seq_mode == MD_INCR && !seq_last) |=> out_tag == TAG_W'($past(out_tag) + 1'b1));

  assert_index_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && seq_mode == MD_INDEX && !seq_last) |=> out_tag > $past(out_tag));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |=> err_mode);

  assert_stall_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_tag));
endmodule

bind tag_stream_expander tsx_checker #(.TAG_W(TAG_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_tag(out_tag), .err_mode(err_mode),
  .hdr_phase(hdr_phase), .data_fire(data_fire), .seq_last(seq_last),
  .seq_mode(seq_mode)
);

// File: tb/test_tag_stream_expander.sv
module test_tag_stream_expander;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_ready;
  logic        out_valid;
  logic [8:0]  out_tag;
  logic [31:0] out_data;
  logic        out_ready = 1'b1;
  logic        err_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tag_stream_expander i_tag_stream_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .out_valid(out_valid), .out_tag(out_tag),
    .out_data(out_data), .out_ready(out_ready), .err_mode(err_mode)
  );

  // row: {is_data, expected tag, word}
  localparam int NV = 21;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 9'h000, 32'h0002_0010},  // R3 hold tag 0x010, count 2
    {1'b1, 9'h010, 32'hD000_0001},
    {1'b1, 9'h010, 32'hD000_0002},
    {1'b1, 9'h010, 32'hD000_0003},
    {1'b0, 9'h000, 32'h0000_0005},  // R4 single word
    {1'b1, 9'h005, 32'hD000_0004},
    {1'b0, 9'h000, 32'h0003_41FE},  // R5 incr from 0x1FE, wraps
    {1'b1, 9'h1FE, 32'hD000_0005},
    {1'b1, 9'h1FF, 32'hD000_0006},
    {1'b1, 9'h000, 32'hD000_0007},
    {1'b1, 9'h001, 32'hD000_0008},
    {1'b0, 9'h000, 32'h0032_80FA},  // R6 group 0x0F, low bits ignored
    {1'b1, 9'h0F1, 32'hD000_0009},
    {1'b1, 9'h0F4, 32'hD000_000A},
    {1'b1, 9'h0F5, 32'hD000_000B},
    {1'b0, 9'h000, 32'h0000_8030},  // R7 empty mask
    {1'b0, 9'h000, 32'h0000_4007},  // R4 incr, upper half zero
    {1'b1, 9'h007, 32'hD000_000C},
    {1'b0, 9'h000, 32'h8001_81F0},  // R6 mask bits 0 and 15
    {1'b1, 9'h1F0, 32'hD000_000D},
    {1'b1, 9'h1FF, 32'hD000_000E}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, look 2 ns later, commit at the next posedge
  task automatic offer(input logic v, input logic [31:0] w, input logic rdy);
    @(negedge clk);
    in_valid  = v;
    in_word   = w;
    out_ready = rdy;
    #2;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check(in_ready === 1'b1 && out_valid === 1'b0 && err_mode === 1'b0, "R1",
          "reset ready/valid/err", {in_ready, out_valid, err_mode}, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;

    // vector walk
    for (int i = 0; i < NV; i++) begin
      offer(1'b1, VEC[i][31:0], 1'b1);
      if (VEC[i][41]) begin
        check(out_valid === 1'b1 && out_tag === VEC[i][40:32] && out_data === VEC[i][31:0],
              "R3/R5/R6", "pair", {out_valid, out_tag, out_data}, {1'b1, VEC[i][40:32], VEC[i][31:0]});
      end else begin
        check(out_valid === 1'b0 && in_ready === 1'b1, "R2", "descriptor silent",
              {out_valid, in_ready}, 2'b01);
      end
    end
    check(err_mode === 1'b0, "R8", "no error on legal modes", err_mode, 1'b0);

    // R10 and R9: gaps and stalls inside a hold burst
    offer(1'b1, 32'h0001_0022, 1'b1);
    offer(1'b0, 32'hDEAD_0000, 1'b1);
    check(out_valid === 1'b0, "R10", "no pair without input", out_valid, 1'b0);
    offer(1'b1, 32'hE000_0001, 1'b0);
    check(in_ready === 1'b0 && out_valid === 1'b1 && out_tag === 9'h022, "R9",
          "stall blocks input", {in_ready, out_valid, out_tag}, {2'b01, 9'h022});
    offer(1'b1, 32'hE000_0001, 1'b0);
    check(out_tag === 9'h022 && in_ready === 1'b0, "R9", "tag held in stall",
          {in_ready, out_tag}, {1'b0, 9'h022});
    offer(1'b1, 32'hE000_0001, 1'b1);
    check(in_ready === 1'b1 && out_data === 32'hE000_0001, "R9", "release",
          {in_ready, out_data}, {1'b1, 32'hE000_0001});
    offer(1'b1, 32'hE000_0002, 1'b1);
    check(out_valid === 1'b1 && out_tag === 9'h022, "R10", "second word after gap",
          {out_valid, out_tag}, {1'b1, 9'h022});
    offer(1'b1, 32'h0000_0033, 1'b1);
    check(out_valid === 1'b0, "R4", "burst closed after count+1", out_valid, 1'b0);
    offer(1'b1, 32'hE000_0003, 1'b1);
    check(out_tag === 9'h033 && out_valid === 1'b1, "R4", "next burst tag",
          {out_valid, out_tag}, {1'b1, 9'h033});

    // R8 reserved mode
    offer(1'b1, 32'h0005_C0AA, 1'b1);
    check(out_valid === 1'b0, "R8", "reserved desc silent", out_valid, 1'b0);
    offer(1'b1, 32'h0000_0003, 1'b1);
    check(out_valid === 1'b0 && err_mode === 1'b1, "R8", "next word is descriptor, flag set",
          {out_valid, err_mode}, 2'b01);
    offer(1'b1, 32'hE000_0004, 1'b1);
    check(out_valid === 1'b1 && out_tag === 9'h003 && err_mode === 1'b1, "R8",
          "flag sticky, stream continues", {out_valid, out_tag, err_mode}, {1'b1, 9'h003, 1'b1});
    offer(1'b0, 32'h0, 1'b1);
    @(negedge clk);
    check(err_mode === 1'b1, "R8", "flag still set", err_mode, 1'b1);

    // R1 reset mid-burst clears state and flag
    offer(1'b1, 32'h0004_0044, 1'b1);
    offer(1'b0, 32'h0, 1'b1);
    rst_n = 1'b0;
    #2;
    check(err_mode === 1'b0 && in_ready === 1'b1, "R1", "reset clears flag and burst",
          {err_mode, in_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    offer(1'b1, 32'hE000_0005, 1'b1);
    check(out_valid === 1'b0, "R1", "first word after reset is descriptor", out_valid, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule